// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Requester

This block holds the device-side interrupt logic for a short chain of peripherals. Each slot in the chain keeps a ready flag, an interrupt-enable flag and an 8-bit vector. The peripheral sets the ready flag when it has something to report. A read of its data register clears it. The CPU writes the enable flag and the vector through a small configuration port. A slot asks for service only while both flags are set. The requests of all slots are merged onto one shared request line. The block also reports the highest fixed priority level among the slots that are currently asking.

When the CPU grants service, it sends a one-cycle acknowledge strobe into the head of the chain (slot 0). A slot that is not asking forwards the strobe to its neighbour. The first slot that is asking keeps the strobe. That slot alone drives its vector back to the CPU. In the next cycle it withdraws its request. It stays quiet until its ready flag is cleared by a data read, which re-arms it. Priority levels are fixed per slot by a parameter and appear in the status word. The chain order, not the level, decides which slot answers.

Top module: `irq_chain_requester`

## Requirements
- R1: After reset every ready flag, enable flag, claim and vector is zero. The shared request is low, the reported level is 0, and no grant or valid vector is driven.
- R2: The status word read for a slot has the ready flag in bit 15, the enable flag in bit 14 and the slot's fixed priority in bits 10:8. All other bits read as zero. An out-of-range read index returns zero.
- R3: A slot requests only while its ready and enable flags are both set and it has not been claimed. The shared request is the OR of all slot requests.
- R4: The reported level is the largest fixed priority (0 lowest, 7 highest) among the requesting slots. It is 0 when no slot requests.
- R5: The acknowledge strobe enters at slot 0. Non-requesting slots pass it on and the first requesting slot absorbs it. Exactly that slot's grant bit is high and its vector is driven with the valid flag set. With no requester, the grant bits, the vector and the valid flag are all zero.
- R6: A slot that absorbed the acknowledge drops its request from the next cycle on. Its ready flag stays set, and a further ready-set pulse does not re-arm it.
- R7: A data-read pulse clears the slot's ready flag and its claim. A ready-set pulse in the same cycle wins, leaving the slot ready and requesting again.
- R8: Clearing a slot's enable flag removes its request without touching its ready flag.
- R9: A vector write (configuration select 1, data bits 7:0) or an enable write (select 0, data bit 14) to a slot index takes effect at the next clock edge. The new vector is returned by the next acknowledge the slot absorbs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_ready_set | input | N_DEV | Per-slot pulse from the peripheral setting its ready flag |
| dev_data_read | input | N_DEV | Per-slot pulse for a data-register read; clears ready |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Slot index for the configuration write |
| cfg_sel | input | 1 | 0 writes the enable flag (bit 14), 1 writes the vector (bits 7:0) |
| cfg_wdata | input | 16 | Configuration write data |
| rd_idx | input | IDX_W | Slot index for the status read |
| rd_status | output | 16 | Status word of the selected slot |
| iack_in | input | 1 | One-cycle acknowledge strobe from the CPU into slot 0 |
| irq | output | 1 | Shared interrupt request |
| irq_level | output | 3 | Highest priority among requesting slots |
| iack_grant | output | N_DEV | One-hot mark of the slot that absorbed the acknowledge |
| iack_vec | output | 8 | Vector of the absorbing slot |
| iack_vec_valid | output | 1 | High while a slot answers the acknowledge |

## Verification
The hardest case to reach from the ports is an acknowledge that has to pass one or more non-requesting slots before a later slot absorbs it. It is harder still when that slot is not the one with the highest level. The bench arms only slots 1 and 3, with slot 3 carrying the higher level, and strobes the acknowledge twice. This shows that the chain order picks the answer and that the first claim then frees the chain for the second. A read and a ready-set landing in the same cycle on a claimed slot is set up by first claiming the slot and then pulsing both inputs together.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int STAT_W   = 16;
  localparam int RDY_BIT  = 15;
  localparam int IEN_BIT  = 14;
  localparam int PRIO_LSB = 8;
  localparam int PRIO_W   = 3;

  typedef enum logic {
    CFG_CTRL   = 1'b0,
    CFG_VECTOR = 1'b1
  } cfg_sel_e;

  // A slot asks for service while armed and not yet claimed
  function automatic logic slot_request(input logic ready, input logic enable,
                                        input logic claimed);
    return ready & enable & ~claimed;
  endfunction

  // Status word as seen by the CPU
  function automatic logic [STAT_W-1:0] status_word(input logic ready,
                                                    input logic enable,
                                                    input logic [PRIO_W-1:0] prio);
    logic [STAT_W-1:0] w;
    w = '0;
    w[RDY_BIT] = ready;
    w[IEN_BIT] = enable;
    w[PRIO_LSB +: PRIO_W] = prio;
    return w;
  endfunction

  // Larger of two levels
  function automatic logic [PRIO_W-1:0] level_max(input logic [PRIO_W-1:0] a,
                                                  input logic [PRIO_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irq_chain_slot.sv
module irq_chain_slot
  import irq_chain_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_set,
  input  logic             data_read,
  input  logic             en_we,
  input  logic             en_wdata,
  input  logic             vec_we,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic             ack_in,
  output logic             ack_out,
  output logic             grant,
  output logic             req,
  output logic             ready,
  output logic             enable,
  output logic [VEC_W-1:0] vector
);
  logic             ready_q;
  logic             enable_q;
  logic             claimed_q;
  logic [VEC_W-1:0] vector_q;

  assign req     = slot_request(ready_q, enable_q, claimed_q);
  assign grant   = ack_in & req;
  assign ack_out = ack_in & ~req;
  assign ready   = ready_q;
  assign enable  = enable_q;
  assign vector  = vector_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      enable_q  <= 1'b0;
      claimed_q <= 1'b0;
      vector_q  <= '0;
    end else begin
      if (ready_set)      ready_q <= 1'b1;
      else if (data_read) ready_q <= 1'b0;

      if (data_read)      claimed_q <= 1'b0;
      else if (grant)     claimed_q <= 1'b1;

      if (en_we)  enable_q <= en_wdata;
      if (vec_we) vector_q <= vec_wdata;
    end
  end
endmodule

// File: rtl/irq_chain_level.sv
module irq_chain_level
  import irq_chain_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter logic [N_DEV*PRIO_W-1:0] DEV_PRIO = '0
) (
  input  logic [N_DEV-1:0]  req,
  output logic [PRIO_W-1:0] level
);
  always_comb begin
    level = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (req[i]) level = level_max(level, DEV_PRIO[i*PRIO_W +: PRIO_W]);
    end
  end
endmodule

// File: rtl/irq_chain_vecsel.sv
module irq_chain_vecsel #(
  parameter int N_DEV = 4,
  parameter int VEC_W = 8
) (
  input  logic [N_DEV-1:0]            grant,
  input  logic [N_DEV-1:0][VEC_W-1:0] vecs,
  output logic [VEC_W-1:0]            vec,
  output logic                        valid
);
  always_comb begin
    vec = '0;
    for (int i = 0; i < N_DEV; i++) begin
      vec = vec | ({VEC_W{grant[i]}} & vecs[i]);
    end
  end
  assign valid = |grant;
endmodule

// File: rtl/irq_chain_requester.sv
module irq_chain_requester
  import irq_chain_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter int VEC_W = 8,
  parameter logic [N_DEV*irq_chain_pkg::PRIO_W-1:0] DEV_PRIO = 12'b110_001_101_010,
  parameter int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DEV-1:0]  dev_ready_set,
  input  logic [N_DEV-1:0]  dev_data_read,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_sel,
  input  logic [15:0]       cfg_wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [15:0]       rd_status,
  input  logic              iack_in,
  output logic              irq,
  output logic [2:0]        irq_level,
  output logic [N_DEV-1:0]  iack_grant,
  output logic [VEC_W-1:0]  iack_vec,
  output logic              iack_vec_valid
);
  logic [N_DEV:0]              ack_link;
  logic [N_DEV-1:0]            dev_req;
  logic [N_DEV-1:0]            dev_ready;
  logic [N_DEV-1:0]            dev_enable;
  logic [N_DEV-1:0]            en_we;
  logic [N_DEV-1:0]            vec_we;
  logic [N_DEV-1:0][VEC_W-1:0] dev_vec;
  logic [N_DEV-1:0][15:0]      dev_status;
  logic [PRIO_W-1:0]           level_w;

  assign ack_link[0] = iack_in;

  for (genvar g = 0; g < N_DEV; g++) begin : g_slot
    assign en_we[g]  = cfg_wr && (cfg_idx == IDX_W'(g)) && (cfg_sel_e'(cfg_sel) == CFG_CTRL);
    assign vec_we[g] = cfg_wr && (cfg_idx == IDX_W'(g)) && (cfg_sel_e'(cfg_sel) == CFG_VECTOR);

    irq_chain_slot #(.VEC_W(VEC_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready_set (dev_ready_set[g]),
      .data_read (dev_data_read[g]),
      .en_we     (en_we[g]),
      .en_wdata  (cfg_wdata[IEN_BIT]),
      .vec_we    (vec_we[g]),
      .vec_wdata (cfg_wdata[VEC_W-1:0]),
      .ack_in    (ack_link[g]),
      .ack_out   (ack_link[g+1]),
      .grant     (iack_grant[g]),
      .req       (dev_req[g]),
      .ready     (dev_ready[g]),
      .enable    (dev_enable[g]),
      .vector    (dev_vec[g])
    );

    assign dev_status[g] = status_word(dev_ready[g], dev_enable[g],
                                       DEV_PRIO[g*PRIO_W +: PRIO_W]);
  end

  irq_chain_level #(.N_DEV(N_DEV), .DEV_PRIO(DEV_PRIO)) u_level (
    .req   (dev_req),
    .level (level_w)
  );

  irq_chain_vecsel #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_vecsel (
    .grant (iack_grant),
    .vecs  (dev_vec),
    .vec   (iack_vec),
    .valid (iack_vec_valid)
  );

  assign irq       = |dev_req;
  assign irq_level = level_w;

  always_comb begin
    rd_status = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (rd_idx == IDX_W'(i)) rd_status = dev_status[i];
    end
  end
endmodule

// File: rtl/irq_chain_checker.sv
module irq_chain_checker #(
  parameter int N_DEV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iack_in,
  input logic             irq,
  input logic [2:0]       irq_level,
  input logic [N_DEV-1:0] iack_grant,
  input logic             iack_vec_valid,
  input logic [N_DEV-1:0] dev_req,
  input logic [N_DEV-1:0] dev_ready,
  input logic [N_DEV-1:0] dev_ready_set,
  input logic [N_DEV-1:0] dev_data_read
);
  AST_IRQ_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (dev_req != '0));  // R3
  AST_LEVEL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> irq_level == 3'd0);  // R4
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(iack_grant));  // R5
  AST_GRANT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_grant != '0) |-> iack_in);  // R5
  AST_VALID_MATCHES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    iack_vec_valid == (iack_grant != '0));  // R5
  AST_ACK_FINDS_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_in && irq) |-> iack_vec_valid);  // R5

  for (genvar g = 0; g < N_DEV; g++) begin : g_chk
    AST_CLAIM_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (iack_grant[g] && !dev_data_read[g]) |=> !dev_req[g]);  // R6
    AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_data_read[g] && !dev_ready_set[g]) |=> !dev_ready[g]);  // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ready_set[g] |=> dev_ready[g]);  // R7
  end
endmodule

bind irq_chain_requester irq_chain_checker #(.N_DEV(N_DEV)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .iack_in        (iack_in),
  .irq            (irq),
  .irq_level      (irq_level),
  .iack_grant     (iack_grant),
  .iack_vec_valid (iack_vec_valid),
  .dev_req        (dev_req),
  .dev_ready      (dev_ready),
  .dev_ready_set  (dev_ready_set),
  .dev_data_read  (dev_data_read)
);

// File: tb/tb_irq_chain_requester.sv
module tb_irq_chain_requester;
  localparam int N = 4;
  localparam logic [11:0] PRIO = 12'b110_001_101_010; // slot3=6 slot2=1 slot1=5 slot0=2

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] dev_ready_set = '0;
  logic [N-1:0] dev_data_read = '0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0] rd_idx = '0;
  logic [15:0] rd_status;
  logic iack_in = 1'b0;
  logic irq;
  logic [2:0] irq_level;
  logic [N-1:0] iack_grant;
  logic [7:0] iack_vec;
  logic iack_vec_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_chain_requester #(.N_DEV(N), .VEC_W(8), .DEV_PRIO(PRIO)) dut (
    .clk(clk), .rst_n(rst_n), .dev_ready_set(dev_ready_set), .dev_data_read(dev_data_read),
    .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_idx(rd_idx), .rd_status(rd_status), .iack_in(iack_in), .irq(irq),
    .irq_level(irq_level), .iack_grant(iack_grant), .iack_vec(iack_vec),
    .iack_vec_valid(iack_vec_valid));

  function automatic logic [15:0] exp_status(int idx, bit rdy, bit en);
    return {rdy, en, 3'b000, PRIO[idx*3 +: 3], 8'h00};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(int idx, bit sel, logic [15:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 2'(idx); cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] set_m, logic [N-1:0] rd_m);
    @(negedge clk);
    dev_ready_set = set_m; dev_data_read = rd_m;
    @(negedge clk);
    dev_ready_set = '0; dev_data_read = '0;
  endtask

  task automatic status_of(int idx, output logic [15:0] s);
    rd_idx = 2'(idx);
    #1 s = rd_status;
  endtask

  // Raise ack for one cycle; capture the answer before the edge
  task automatic ack(output logic [3:0] g, output logic [7:0] v, output logic val);
    @(negedge clk);
    iack_in = 1'b1;
    #1 g = iack_grant; v = iack_vec; val = iack_vec_valid;
    @(negedge clk);
    iack_in = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [15:0] s;
    do_reset();
    #1;
    check("R1 irq", irq, 0);
    check("R1 level", irq_level, 0);
    check("R1 valid", iack_vec_valid, 0);
    for (int i = 0; i < N; i++) begin
      status_of(i, s);
      check("R1/R2 status", s, exp_status(i, 0, 0));
    end
  endtask

  task automatic t_gating();
    logic [15:0] s;
    do_reset();
    pulse(4'b0100, 4'b0000);           // ready on slot 2, not enabled
    #1;
    check("R3 no enable no irq", irq, 0);
    status_of(2, s);
    check("R2 ready bit15", s, exp_status(2, 1, 0));
    cfg_write(2, 1'b0, 16'h4000);
    #1;
    check("R3 irq raised", irq, 1);
    check("R4 level slot2", irq_level, 1);
    status_of(2, s);
    check("R9/R2 enable bit14", s, exp_status(2, 1, 1));
    cfg_write(3, 1'b0, 16'h4000);
    pulse(4'b1000, 4'b0000);
    #1;
    check("R4 highest level", irq_level, 6);
    cfg_write(3, 1'b0, 16'h0000);
    #1;
    check("R8 level after disable", irq_level, 1);
    status_of(3, s);
    check("R8 ready kept", s, exp_status(3, 1, 0));
  endtask

  task automatic t_chain();
    logic [3:0] g; logic [7:0] v; logic val; logic [15:0] s;
    do_reset();
    for (int i = 0; i < N; i++) begin
      cfg_write(i, 1'b0, 16'h4000);
      cfg_write(i, 1'b1, 16'h0040 + 16'(i));
    end
    pulse(4'b1010, 4'b0000);
    #1;
    check("R4 level 5 and 6", irq_level, 6);
    ack(g, v, val);
    check("R5 first grant", g, 4'b0010);
    check("R5 first vector", v, 8'h41);
    check("R5 first valid", val, 1);
    check("R6 still irq", irq, 1);
    check("R6 level after claim", irq_level, 6);
    status_of(1, s);
    check("R6 ready stays", s, exp_status(1, 1, 1));
    ack(g, v, val);
    check("R5 second grant", g, 4'b1000);
    check("R5 second vector", v, 8'h43);
    check("R6 all claimed irq", irq, 0);
    check("R4 idle level", irq_level, 0);
    ack(g, v, val);
    check("R5 empty grant", g, 4'b0000);
    check("R5 empty vector", v, 8'h00);
    check("R5 empty valid", val, 0);
    pulse(4'b0010, 4'b0000);
    #1;
    check("R6 set does not re-arm", irq, 0);
    pulse(4'b0000, 4'b0010);
    pulse(4'b0010, 4'b0000);
    #1;
    check("R7 re-armed irq", irq, 1);
    check("R7 re-armed level", irq_level, 5);
  endtask

  task automatic t_same_cycle();
    logic [3:0] g; logic [7:0] v; logic val; logic [15:0] s;
    do_reset();
    cfg_write(0, 1'b0, 16'h4000);
    pulse(4'b0001, 4'b0000);
    ack(g, v, val);
    check("R5 slot0 grant", g, 4'b0001);
    check("R6 slot0 claimed", irq, 0);
    pulse(4'b0001, 4'b0001);
    #1;
    status_of(0, s);
    check("R7 set wins ready", s, exp_status(0, 1, 1));
    check("R7 set wins irq", irq, 1);
    pulse(4'b0000, 4'b0001);
    #1;
    status_of(0, s);
    check("R7 read clears", s, exp_status(0, 0, 1));
    check("R7 read drops irq", irq, 0);
  endtask

  task automatic t_vector();
    logic [3:0] g; logic [7:0] v; logic val;
    do_reset();
    cfg_write(2, 1'b0, 16'h4000);
    cfg_write(2, 1'b1, 16'h009A);
    pulse(4'b0100, 4'b0000);
    ack(g, v, val);
    check("R9 vector loaded", v, 8'h9A);
    check("R5 slot2 grant", g, 4'b0100);
    cfg_write(2, 1'b1, 16'h003C);
    pulse(4'b0100, 4'b0100);
    ack(g, v, val);
    check("R9 vector rewritten", v, 8'h3C);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_gating();
    t_chain();
    t_same_cycle();
    t_vector();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule